// File: doc/BRIEF.md
# Wide-to-Narrow Word Unpacker with Reset-Latched Byte Order

This block sits on the read side of a bus-matching FIFO. It splits each wide word it takes from storage into a fixed number of narrower words. With the default parameters a 36-bit word comes out as two 18-bit halves. Setting `WIDE_W` to 18 gives two 9-bit halves instead. Every narrow piece is an exact bit slice of the wide word, with no padding.

The order of the pieces is chosen by the `endian_sel` pin. The block samples this pin only while the master reset `mrst_n` is held low. A value of 1 selects most-significant-part-first and a value of 0 selects least-significant-part-first. Once reset is released, the order stays fixed until the next master reset.

Both data interfaces are valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The input side is back-pressured while any piece of the held word other than the last is still waiting to leave. The output side holds its data steady for as long as the consumer stalls. A plain status output, `low_power`, reports a low-power idle state after a run of idle cycles. It drops in the same cycle that a new word is offered.

Top module: `wide_unpacker`

## Requirements
- R1: With `WIDE_W` and `RATIO` as parameters, each accepted wide word yields exactly `RATIO` narrow words of `WIDE_W/RATIO` bits. Piece number k (counting from 0) is bits [k*N +: N] of the word, where N = `WIDE_W/RATIO`.
- R2: When `endian_sel` was 1 during reset, the pieces leave in order of decreasing k, so bits [WIDE_W-1 -: N] come out first.
- R3: When `endian_sel` was 0 during reset, the pieces leave in order of increasing k, so bits [N-1:0] come out first.
- R4: `endian_sel` is sampled on each clock edge while `mrst_n` is low. Changes on it after `mrst_n` goes high have no effect on the piece order until the next reset.
- R5: Master reset (synchronous, active low) discards any held word. After release, `out_valid` is 0 and `in_ready` is 1, and the next accepted word starts at its first piece.
- R6: `in_ready` is 1 exactly when no word is held, or when the last piece of the held word is being taken in the same cycle (`out_valid` and `out_ready` both high). An offered word is not accepted otherwise.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value on the next cycle.
- R8: `low_power` rises after `IDLE_CYCLES` consecutive cycles with no word held and `in_valid` low. It is 0 combinationally in any cycle where `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| endian_sel | input | 1 | Piece order select, sampled only during reset (1 = most significant first) |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Block can take a wide word |
| in_data | input | WIDE_W | Wide word |
| out_valid | output | 1 | Narrow word present |
| out_ready | input | 1 | Consumer takes the narrow word |
| out_data | output | WIDE_W/RATIO | Narrow word |
| low_power | output | 1 | Idle low-power indication |

## Verification
The main function is tried in two ways. The first is random words under random valid and ready patterns, which tests whether pieces are lost, duplicated or reordered under back-pressure. The second is directed words: all ones, alternating bits, and single bits on either side of the slice boundary. These show an off-by-one slice or a swapped order that random data could hide. Both orders are run while `endian_sel` is toggled after release, which separates a latched mode from a live pin. A reset issued in the middle of a word shows whether stale pieces survive into the next word.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/unpk_mode_latch.sv
module unpk_mode_latch
  import unpk_pkg::*;
(
  input  logic   clk,
  input  logic   mrst_n,
  input  logic   endian_sel,
  output order_e order
);
  always_ff @(posedge clk) begin
    if (!mrst_n) order <= order_e'(endian_sel);
  end

  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(order));
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl #(
  parameter int WIDE_W = 36,
  parameter int RATIO  = 2,
  localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] held_word,
  output logic [IDX_W-1:0]  piece_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

  logic full_q;
  logic last_take;
  logic in_fire;

  assign last_take = full_q && out_ready && (piece_idx == LAST_IDX);
  assign in_ready  = !full_q || last_take;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = full_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      full_q    <= 1'b0;
      piece_idx <= '0;
      held_word <= '0;
    end else if (in_fire) begin
      full_q    <= 1'b1;
      piece_idx <= '0;
      held_word <= in_data;
    end else if (full_q && out_ready) begin
      if (piece_idx == LAST_IDX) begin
        full_q    <= 1'b0;
        piece_idx <= '0;
      end else begin
        piece_idx <= piece_idx + 1'b1;
      end
    end
  end

  // R5
  reset_clears_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> !out_valid && in_ready);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    out_valid && !(out_ready && piece_idx == LAST_IDX) |=> out_valid && $stable(held_word));

  // R1
  word_starts_first_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    in_valid && in_ready |=> out_valid && piece_idx == '0);
endmodule

// File: rtl/unpk_slicer.sv
module unpk_slicer
  import unpk_pkg::*;
#(
  parameter int WIDE_W = 36,
  parameter int RATIO  = 2,
  localparam int NARROW_W = WIDE_W / RATIO,
  localparam int IDX_W    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic [WIDE_W-1:0]   word,
  input  logic [IDX_W-1:0]    idx,
  input  order_e              order,
  output logic [NARROW_W-1:0] piece
);
  logic [NARROW_W-1:0] slices [RATIO];
  logic [IDX_W-1:0]    sel;

  for (genvar k = 0; k < RATIO; k++) begin : g_slice
    assign slices[k] = word[k*NARROW_W +: NARROW_W];
  end

  always_comb begin
    if (order == ORDER_MSB_FIRST) sel = IDX_W'(RATIO - 1) - idx;
    else                          sel = idx;
  end

  assign piece = slices[sel];
endmodule

// File: rtl/unpk_idle.sv
module unpk_idle #(
  parameter int IDLE_CYCLES = 8,
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic in_valid,
  input  logic busy,
  output logic low_power
);
  logic [CNT_W-1:0] cnt_q;
  logic             asleep_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (in_valid || busy) begin
      cnt_q    <= '0;
      asleep_q <= 1'b0;
    end else if (cnt_q == CNT_W'(IDLE_CYCLES - 1)) begin
      asleep_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low_power = asleep_q && !in_valid;

  // R8
  sleep_only_idle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    low_power |-> !in_valid && !busy);
endmodule

// File: rtl/wide_unpacker.sv
module wide_unpacker
  import unpk_pkg::*;
#(
  parameter int WIDE_W      = 36,
  parameter int RATIO       = 2,
  parameter int IDLE_CYCLES = 8
) (
  input  logic                      clk,
  input  logic                      mrst_n,
  input  logic                      endian_sel,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WIDE_W-1:0]         in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WIDE_W/RATIO-1:0]   out_data,
  output logic                      low_power
);
  localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1;

  order_e            order;
  logic [WIDE_W-1:0] held_word;
  logic [IDX_W-1:0]  piece_idx;

  unpk_mode_latch u_mode (
    .clk(clk), .mrst_n(mrst_n), .endian_sel(endian_sel), .order(order)
  );

  unpk_ctrl #(.WIDE_W(WIDE_W), .RATIO(RATIO)) u_ctrl (
    .clk(clk), .mrst_n(mrst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .held_word(held_word), .piece_idx(piece_idx)
  );

  unpk_slicer #(.WIDE_W(WIDE_W), .RATIO(RATIO)) u_slice (
    .word(held_word), .idx(piece_idx), .order(order), .piece(out_data)
  );

  unpk_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .mrst_n(mrst_n), .in_valid(in_valid), .busy(out_valid),
    .low_power(low_power)
  );

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/wide_unpacker_test.sv
module wide_unpacker_test;
  localparam int WIDE_W = 36;
  localparam int RATIO  = 2;
  localparam int NW     = WIDE_W / RATIO;
  localparam int IDLE   = 8;

  logic clk = 1'b0;
  logic mrst_n = 1'b0;
  logic endian_sel = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [WIDE_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NW-1:0] out_data;
  logic low_power;

  int checks = 0;
  int fails  = 0;
  bit exp_big = 1'b0;
  bit scramble = 1'b0;
  bit stall_prev = 1'b0;
  logic [NW-1:0] stall_data;
  logic [NW-1:0] q[$];

  always #4 clk = ~clk;

  wide_unpacker #(.WIDE_W(WIDE_W), .RATIO(RATIO), .IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .mrst_n(mrst_n), .endian_sel(endian_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .low_power(low_power)
  );

  function automatic logic [NW-1:0] piece_of(logic [WIDE_W-1:0] w, int k, bit big);
    int p = big ? (RATIO - 1 - k) : k;
    return w[p*NW +: NW];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit iv, logic [WIDE_W-1:0] d, bit ordy);
    bit exp_rdy;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    if (scramble) endian_sel = 1'($urandom);
    #1;
    exp_rdy = (q.size() == 0) || (q.size() == 1 && ordy);
    chk(in_ready == exp_rdy, "R6", "in_ready", in_ready, exp_rdy);
    chk(out_valid == (q.size() != 0), "R1", "out_valid", out_valid, q.size() != 0);
    if (stall_prev)
      chk(out_valid && out_data == stall_data, "R7", "stalled data", out_data, stall_data);
    stall_prev = out_valid && !ordy;
    stall_data = out_data;
    if (out_valid && ordy && q.size() != 0) begin
      logic [NW-1:0] e = q.pop_front();
      chk(out_data == e, exp_big ? "R2" : "R3", "piece", out_data, e);
    end
    if (iv && in_ready)
      for (int k = 0; k < RATIO; k++) q.push_back(piece_of(d, k, exp_big));
  endtask

  task automatic do_reset(bit big, int n);
    @(negedge clk);
    mrst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; endian_sel = big;
    repeat (n) @(negedge clk);
    mrst_n = 1'b1;
    exp_big = big; q.delete(); stall_prev = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R5", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R5", "in_ready after reset", in_ready, 1);
  endtask

  function automatic logic [WIDE_W-1:0] rnd_word();
    logic [63:0] r = {$urandom, $urandom};
    return r[WIDE_W-1:0];
  endfunction

  task automatic random_run(int n);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 4) != 0, rnd_word(), ($urandom % 3) != 0);
  endtask

  task automatic directed_words();
    logic [WIDE_W-1:0] dir [5];
    dir[0] = '1;
    dir[1] = {(WIDE_W/2){2'b10}};
    dir[2] = WIDE_W'(1) << (NW - 1);
    dir[3] = WIDE_W'(1) << NW;
    dir[4] = WIDE_W'(1);
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, dir[i], 1'b1);
      for (int k = 0; k < RATIO; k++) cycle(1'b0, '0, 1'b1);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2 * RATIO + 2; i++) cycle(1'b0, '0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R5 reset state with most-significant-first order
    do_reset(1'b1, 3);
    repeat (2) cycle(1'b0, '0, 1'b0);
    chk(low_power == 1'b0, "R8", "low_power early", low_power, 0);
    // R2 with endian pin toggled after release (R4)
    scramble = 1'b1;
    directed_words();
    random_run(400);
    drain();
    // R8 idle entry and immediate exit
    repeat (IDLE + 4) cycle(1'b0, '0, 1'b0);
    chk(low_power == 1'b1, "R8", "low_power after idle", low_power, 1);
    @(negedge clk);
    in_valid = 1'b1; #1;
    chk(low_power == 1'b0, "R8", "low_power on offer", low_power, 0);
    in_valid = 1'b0;
    // R5 reset in the middle of a word
    scramble = 1'b0;
    cycle(1'b1, rnd_word(), 1'b0);
    cycle(1'b0, '0, 1'b1);
    do_reset(1'b0, 2);
    // R3 with endian pin toggled after release (R4)
    scramble = 1'b1;
    directed_words();
    random_run(400);
    drain();
    // back to MSB-first, full back-pressure stretches (R7)
    do_reset(1'b1, 1);
    for (int i = 0; i < 200; i++)
      cycle(1'b1, rnd_word(), ($urandom % 5) == 0);
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule